// File: doc/BRIEF.md
# Read command to RapidIO request header mapper

This block sits between a memory-mapped read port and the logical layer of a RapidIO endpoint. Each accepted read command, carrying a 32-bit byte address and a burst length in 32-bit words, becomes one read request header. The header holds a destination ID, a 34-bit RapidIO address, a word pointer and a four-bit read size code. The block can also refuse a command. It does so when no enabled translation window claims the address, or when the burst length has no size code. In that case it still takes the command off the bus, drops it, and pulses an error line.

Software sets up the translation windows through a small register port. Each window has four 32-bit registers: base, mask, offset and control. When a command hits a window, that window picks the target endpoint. It also replaces the masked high address bits with its offset, so different endpoints can each see a slice of the local address space. Headers leave through a valid/ready register. While that register is full and stalled, the command port reports wait.

Top module: `rmap_read_mapper`

## Requirements
- R1: The register port uses byte offsets, and only bits [1:0] are ignored. Window w has four registers: base at 16·w, mask at 16·w+4, offset at 16·w+8 and control at 16·w+12. In the control register, bit 0 enables the window and bits [23:16] hold its destination ID. A write takes effect at the clock edge. A read returns the value last written, combinationally. Offsets beyond the last window read zero. After reset every register reads zero.
- R2: A window claims a command when its enable bit is 1 and (address & mask) equals (base & mask). A disabled window never claims a command.
- R3: When several windows claim a command, the lowest-numbered window is used.
- R4: The header address is {(address & ~mask) | (offset & mask), 2'b00} (34 bits), taken from the chosen window. The header destination is that window's control bits [23:16].
- R5: The burst length sets the size code (rdsize) and word pointer (wdptr) as follows. Length 1 gives rdsize 4'b1000, with wdptr equal to address bit 2. Length 2 gives 4'b1011 with wdptr 0. Lengths 3 to 4 give 4'b1011 with wdptr 1.
- R6: Lengths 5 to 8 give rdsize 4'b1100 with wdptr 0. Lengths 9 to 16 give 4'b1100 with wdptr 1.
- R7: Lengths 17 to 24 give rdsize 4'b1101 with wdptr 0. Lengths 25 to 32 give 4'b1101 with wdptr 1. Lengths 33 to 40 give 4'b1110 with wdptr 0.
- R8: If no enabled window claims a command, the command is still accepted. No header is produced, and map_err is high for exactly one cycle.
- R9: A burst length of 0, or of more than 40, is accepted, produces no header and pulses map_err for one cycle.
- R10: While out_valid is 1 and out_ready is 0, the header fields hold steady and avs_waitrequest is 1. Otherwise avs_waitrequest is 0.
- R11: A command is accepted on a clock edge where avs_read is 1 and avs_waitrequest is 0. Its header or error appears in the cycle after that edge. After reset, out_valid and map_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| avs_read | input | 1 | Read command present |
| avs_address | input | 32 | Command byte address |
| avs_burstcount | input | BC_W | Burst length in 32-bit words |
| avs_waitrequest | output | 1 | Command not taken this cycle |
| out_valid | output | 1 | Header available |
| out_ready | input | 1 | Downstream takes the header |
| out_dest | output | 8 | Destination ID |
| out_rio_addr | output | 34 | RapidIO address |
| out_wdptr | output | 1 | Word pointer |
| out_rdsize | output | 4 | Read size code |
| map_err | output | 1 | One-cycle pulse for a dropped command |

## Verification
Register reads are combinational, so the bench checks read data in the same cycle it sets the offset, half a clock later. For a command, both the header and the error pulse come from one register stage. The bench therefore drives the command before an edge and checks outputs at the falling edge that follows. It checks once more a cycle later to confirm the error pulse has ended. For stalls, the bench holds out_ready low for several cycles and samples each one. It then releases out_ready and expects the waiting command's header exactly one edge later.

// File: rtl/rmap_pkg.sv
// Shared constants and types for the read request mapper.
// Assumes a 32-bit local datapath and 8-bit destination IDs.
package rmap_pkg;
    localparam int REG_W        = 32;
    localparam int RIO_AW       = 34;
    localparam int DEST_W       = 8;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_DST_LSB = 16;
    localparam int MAX_BURST    = 40;

    typedef enum logic [3:0] {
        SZ_WORD  = 4'b1000,
        SZ_DW    = 4'b1011,
        SZ_DW4   = 4'b1100,
        SZ_DW12  = 4'b1101,
        SZ_DW20  = 4'b1110
    } rdsize_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [RIO_AW-1:0] addr;
        logic              wdptr;
        rdsize_e           rdsize;
    } hdr_t;
endpackage

// File: rtl/rmap_window_regs.sv
// Register file for the translation windows: base, mask, offset and control
// per window, 16 bytes apart. Writes apply at the clock edge; reads are
// combinational. Assumes cfg_addr is a byte offset with bits [1:0] ignored.
module rmap_window_regs #(
    parameter int NUM_WIN = 4,
    parameter int CFG_AW  = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_wr,
    input  logic [CFG_AW-1:0]                      cfg_addr,
    input  logic [rmap_pkg::REG_W-1:0]             cfg_wdata,
    output logic [rmap_pkg::REG_W-1:0]             cfg_rdata,
    output logic [NUM_WIN-1:0][rmap_pkg::REG_W-1:0] win_base,
    output logic [NUM_WIN-1:0][rmap_pkg::REG_W-1:0] win_mask,
    output logic [NUM_WIN-1:0][rmap_pkg::REG_W-1:0] win_offs,
    output logic [NUM_WIN-1:0][rmap_pkg::REG_W-1:0] win_ctrl
);
    localparam int IDX_W = CFG_AW - 4;

    logic [IDX_W-1:0] sel_win;
    logic [1:0]       sel_reg;

    assign sel_win = cfg_addr[CFG_AW-1:4];
    assign sel_reg = cfg_addr[3:2];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic wr_here;
        assign wr_here = cfg_wr && (sel_win == IDX_W'(w));

        // Purpose: hold this window's four registers, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_base[w] <= '0;
                win_mask[w] <= '0;
                win_offs[w] <= '0;
                win_ctrl[w] <= '0;
            end else if (wr_here) begin
                case (sel_reg)
                    2'd0:    win_base[w] <= cfg_wdata;
                    2'd1:    win_mask[w] <= cfg_wdata;
                    2'd2:    win_offs[w] <= cfg_wdata;
                    default: win_ctrl[w] <= cfg_wdata;
                endcase
            end
        end
    end

    // Purpose: read mux; offsets past the last window return zero.
    always_comb begin
        cfg_rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (sel_win == IDX_W'(w)) begin
                case (sel_reg)
                    2'd0:    cfg_rdata = win_base[w];
                    2'd1:    cfg_rdata = win_mask[w];
                    2'd2:    cfg_rdata = win_offs[w];
                    default: cfg_rdata = win_ctrl[w];
                endcase
            end
        end
    end
endmodule

// File: rtl/rmap_xlate.sv
// Window matcher and address translator. Every enabled window compares the
// masked address with its masked base; the lowest-numbered hit is chosen and
// supplies the destination ID and the offset bits. Purely combinational.
module rmap_xlate #(
    parameter int NUM_WIN = 4
) (
    input  logic [rmap_pkg::REG_W-1:0]              cmd_addr,
    input  logic [NUM_WIN-1:0][rmap_pkg::REG_W-1:0] win_base,
    input  logic [NUM_WIN-1:0][rmap_pkg::REG_W-1:0] win_mask,
    input  logic [NUM_WIN-1:0][rmap_pkg::REG_W-1:0] win_offs,
    input  logic [NUM_WIN-1:0][rmap_pkg::REG_W-1:0] win_ctrl,
    output logic                                    hit,
    output logic [rmap_pkg::DEST_W-1:0]             dest,
    output logic [rmap_pkg::RIO_AW-1:0]             rio_addr
);
    import rmap_pkg::*;

    logic [NUM_WIN-1:0] match;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        assign match[w] = win_ctrl[w][CTRL_EN_BIT] &&
                          ((cmd_addr & win_mask[w]) == (win_base[w] & win_mask[w]));
    end

    // Purpose: pick the lowest matching window by scanning from the top down.
    always_comb begin
        logic [REG_W-1:0] xl;
        hit  = 1'b0;
        dest = '0;
        xl   = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit  = 1'b1;
                dest = win_ctrl[w][CTRL_DST_LSB +: DEST_W];
                xl   = (cmd_addr & ~win_mask[w]) | (win_offs[w] & win_mask[w]);
            end
        end
        rio_addr = {xl, 2'b00};
    end
endmodule

// File: rtl/rmap_size_enc.sv
// Burst length to read size code and word pointer for a 32-bit datapath.
// Lengths of zero or above MAX_BURST are flagged as unsupported.
module rmap_size_enc #(
    parameter int BC_W = 6
) (
    input  logic [BC_W-1:0]  burst,
    input  logic             addr_b2,
    output logic             ok,
    output logic             wdptr,
    output rmap_pkg::rdsize_e rdsize
);
    import rmap_pkg::*;

    // Purpose: range decode of the burst length into the code pair.
    always_comb begin
        ok     = 1'b1;
        wdptr  = 1'b0;
        rdsize = SZ_WORD;
        if (burst == BC_W'(0)) begin
            ok = 1'b0;
        end else if (burst == BC_W'(1)) begin
            rdsize = SZ_WORD;
            wdptr  = addr_b2;
        end else if (burst <= BC_W'(4)) begin
            rdsize = SZ_DW;
            wdptr  = (burst != BC_W'(2));
        end else if (burst <= BC_W'(16)) begin
            rdsize = SZ_DW4;
            wdptr  = (burst > BC_W'(8));
        end else if (burst <= BC_W'(32)) begin
            rdsize = SZ_DW12;
            wdptr  = (burst > BC_W'(24));
        end else if (burst <= BC_W'(MAX_BURST)) begin
            rdsize = SZ_DW20;
        end else begin
            ok = 1'b0;
        end
    end
endmodule

// File: rtl/rmap_read_mapper.sv
// Top level: register file, window translation, size encoding and a one-deep
// output header register with a valid/ready handshake. A command that hits no
// enabled window or has an unsupported length is accepted and dropped with a
// one-cycle error pulse. Assumes BC_W is at least 6.
module rmap_read_mapper #(
    parameter int NUM_WIN = 4,
    parameter int BC_W    = 6,
    parameter int CFG_AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              avs_read,
    input  logic [31:0]       avs_address,
    input  logic [BC_W-1:0]   avs_burstcount,
    output logic              avs_waitrequest,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_dest,
    output logic [33:0]       out_rio_addr,
    output logic              out_wdptr,
    output logic [3:0]        out_rdsize,
    output logic              map_err
);
    import rmap_pkg::*;

    logic [NUM_WIN-1:0][REG_W-1:0] win_base, win_mask, win_offs, win_ctrl;
    logic              x_hit;
    logic [DEST_W-1:0] x_dest;
    logic [RIO_AW-1:0] x_addr;
    logic              s_ok, s_wdptr;
    rdsize_e           s_rdsize;
    logic              accept, good;
    hdr_t              hdr_q;

    rmap_window_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .win_base(win_base), .win_mask(win_mask),
        .win_offs(win_offs), .win_ctrl(win_ctrl)
    );

    rmap_xlate #(.NUM_WIN(NUM_WIN)) i_xlate (
        .cmd_addr(avs_address), .win_base(win_base), .win_mask(win_mask),
        .win_offs(win_offs), .win_ctrl(win_ctrl),
        .hit(x_hit), .dest(x_dest), .rio_addr(x_addr)
    );

    rmap_size_enc #(.BC_W(BC_W)) i_size (
        .burst(avs_burstcount), .addr_b2(avs_address[2]),
        .ok(s_ok), .wdptr(s_wdptr), .rdsize(s_rdsize)
    );

    assign avs_waitrequest = out_valid && !out_ready;
    assign accept          = avs_read && !avs_waitrequest;
    assign good            = x_hit && s_ok;

    // Purpose: output header register with hold-while-stalled behaviour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            hdr_q     <= '0;
        end else if (accept && good) begin
            out_valid <= 1'b1;
            hdr_q     <= '{dest: x_dest, addr: x_addr, wdptr: s_wdptr, rdsize: s_rdsize};
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Purpose: one-cycle error pulse for an accepted but dropped command.
    always_ff @(posedge clk) begin
        if (!rst_n) map_err <= 1'b0;
        else        map_err <= accept && !good;
    end

    assign out_dest     = hdr_q.dest;
    assign out_rio_addr = hdr_q.addr;
    assign out_wdptr    = hdr_q.wdptr;
    assign out_rdsize   = hdr_q.rdsize;
endmodule

// File: rtl/rmap_checker.sv
// Protocol checks for rmap_read_mapper, attached through bind.
module rmap_checker #(
    parameter int BC_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            avs_read,
    input logic            avs_waitrequest,
    input logic            out_valid,
    input logic            out_ready,
    input logic [7:0]      out_dest,
    input logic [33:0]     out_rio_addr,
    input logic            out_wdptr,
    input logic [3:0]      out_rdsize,
    input logic            map_err,
    input logic [BC_W-1:0] avs_burstcount
);
    // R10: a stalled header keeps all its fields
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_dest) &&
        $stable(out_rio_addr) && $stable(out_wdptr) && $stable(out_rdsize));

    // R10: wait is raised exactly when stalled
    a_r10_wait: assert property (@(posedge clk) disable iff (!rst_n)
        avs_waitrequest == (out_valid && !out_ready));

    // R8 / R9: an error pulse always follows an accepted command
    a_r8_err_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        map_err |-> $past(avs_read && !avs_waitrequest));

    // R8: a dropped command never loads a fresh header
    a_r8_no_hdr_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        map_err |-> !$rose(out_valid));

    // R7: the largest code carries a zero word pointer
    a_r7_top_code_wdptr: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_rdsize == 4'b1110 |-> !out_wdptr);

    // R5 / R6 / R7: only the five legal size codes appear
    a_r5_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_rdsize == 4'b1000 || out_rdsize == 4'b1011 ||
                       out_rdsize == 4'b1100 || out_rdsize == 4'b1101 ||
                       out_rdsize == 4'b1110));
endmodule

bind rmap_read_mapper rmap_checker #(.BC_W(BC_W)) i_rmap_checker (
    .clk(clk), .rst_n(rst_n), .avs_read(avs_read),
    .avs_waitrequest(avs_waitrequest), .out_valid(out_valid),
    .out_ready(out_ready), .out_dest(out_dest), .out_rio_addr(out_rio_addr),
    .out_wdptr(out_wdptr), .out_rdsize(out_rdsize), .map_err(map_err),
    .avs_burstcount(avs_burstcount)
);

// File: tb/test_rmap_read_mapper.sv
module test_rmap_read_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        avs_read = 1'b0;
    logic [31:0] avs_address = '0;
    logic [5:0]  avs_burstcount = '0;
    logic        avs_waitrequest;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_dest;
    logic [33:0] out_rio_addr;
    logic        out_wdptr;
    logic [3:0]  out_rdsize;
    logic        map_err;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rmap_read_mapper i_rmap_read_mapper (.*);

    typedef struct packed {
        logic [31:0] addr;
        logic [5:0]  bc;
        logic        err;
        logic [7:0]  dest;
        logic [33:0] rio;
        logic        wdptr;
        logic [3:0]  rdsize;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{32'h1000_0004, 6'd1,  1'b0, 8'h11, 34'h0_8000_0010, 1'b1, 4'b1000}, // R5 R4
        '{32'h1000_0000, 6'd1,  1'b0, 8'h11, 34'h0_8000_0000, 1'b0, 4'b1000}, // R5
        '{32'hC123_4560, 6'd2,  1'b0, 8'hCC, 34'h1_048D_1580, 1'b0, 4'b1011}, // R5 R4
        '{32'hF000_0008, 6'd4,  1'b0, 8'hCC, 34'h1_C000_0020, 1'b1, 4'b1011}, // R5
        '{32'hC000_0000, 6'd3,  1'b0, 8'hCC, 34'h1_0000_0000, 1'b1, 4'b1011}, // R5
        '{32'h1200_0010, 6'd5,  1'b0, 8'h11, 34'h0_8800_0040, 1'b0, 4'b1100}, // R6 R3
        '{32'h1000_0020, 6'd8,  1'b0, 8'h11, 34'h0_8000_0080, 1'b0, 4'b1100}, // R6
        '{32'h1000_0040, 6'd9,  1'b0, 8'h11, 34'h0_8000_0100, 1'b1, 4'b1100}, // R6
        '{32'hC000_0100, 6'd16, 1'b0, 8'hCC, 34'h1_0000_0400, 1'b1, 4'b1100}, // R6
        '{32'hC000_0200, 6'd17, 1'b0, 8'hCC, 34'h1_0000_0800, 1'b0, 4'b1101}, // R7
        '{32'h1000_0000, 6'd24, 1'b0, 8'h11, 34'h0_8000_0000, 1'b0, 4'b1101}, // R7
        '{32'h1000_0000, 6'd25, 1'b0, 8'h11, 34'h0_8000_0000, 1'b1, 4'b1101}, // R7
        '{32'h1000_0000, 6'd32, 1'b0, 8'h11, 34'h0_8000_0000, 1'b1, 4'b1101}, // R7
        '{32'h1000_0000, 6'd33, 1'b0, 8'h11, 34'h0_8000_0000, 1'b0, 4'b1110}, // R7
        '{32'h1000_0000, 6'd40, 1'b0, 8'h11, 34'h0_8000_0000, 1'b0, 4'b1110}, // R7
        '{32'h1000_0000, 6'd41, 1'b1, 8'h00, 34'h0,           1'b0, 4'b0000}, // R9
        '{32'h1000_0000, 6'd0,  1'b1, 8'h00, 34'h0,           1'b0, 4'b0000}, // R9
        '{32'h8000_0000, 6'd1,  1'b1, 8'h00, 34'h0,           1'b0, 4'b0000}, // R8 R2
        '{32'h5000_0000, 6'd1,  1'b1, 8'h00, 34'h0,           1'b0, 4'b0000}  // R8
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Issue one command with out_ready high; check header or error a cycle later.
    task automatic run_cmd(input vec_t v, input string req);
        @(negedge clk);
        avs_read = 1'b1; avs_address = v.addr; avs_burstcount = v.bc;
        @(negedge clk);
        avs_read = 1'b0;
        chk(map_err == v.err, req, 64'(map_err), 64'(v.err));
        chk(out_valid == !v.err, req, 64'(out_valid), 64'(!v.err));
        if (!v.err) begin
            chk(out_dest == v.dest, req, 64'(out_dest), 64'(v.dest));
            chk(out_rio_addr == v.rio, req, 64'(out_rio_addr), 64'(v.rio));
            chk(out_wdptr == v.wdptr, req, 64'(out_wdptr), 64'(v.wdptr));
            chk(out_rdsize == v.rdsize, req, 64'(out_rdsize), 64'(v.rdsize));
        end
        @(negedge clk);
        chk(map_err == 1'b0, "R8 pulse width", 64'(map_err), 64'h0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected < 100000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 and R1 reset state
        chk(out_valid == 1'b0, "R11 reset valid", 64'(out_valid), 64'h0);
        chk(map_err == 1'b0, "R11 reset err", 64'(map_err), 64'h0);
        cfg_addr = 8'h2C;
        #1 chk(cfg_rdata == 32'h0, "R1 reset reg", 64'(cfg_rdata), 64'h0);

        // Window setup: control bit 0 enable, bits 23:16 destination
        reg_wr(8'h00, 32'h1000_0000); reg_wr(8'h04, 32'hF000_0000);
        reg_wr(8'h08, 32'h2000_0000); reg_wr(8'h0C, 32'h0011_0001);
        reg_wr(8'h10, 32'h1200_0000); reg_wr(8'h14, 32'hFF00_0000);
        reg_wr(8'h18, 32'h3400_0000); reg_wr(8'h1C, 32'h0022_0001);
        reg_wr(8'h20, 32'hC000_0000); reg_wr(8'h24, 32'hC000_0000);
        reg_wr(8'h28, 32'h4000_0000); reg_wr(8'h2C, 32'h00CC_0001);
        reg_wr(8'h30, 32'h8000_0000); reg_wr(8'h34, 32'hC000_0000);
        reg_wr(8'h3C, 32'h0033_0000);

        // R1 readback
        cfg_addr = 8'h2C;
        #1 chk(cfg_rdata == 32'h00CC_0001, "R1 readback ctrl", 64'(cfg_rdata), 64'h00CC_0001);
        cfg_addr = 8'h14;
        #1 chk(cfg_rdata == 32'hFF00_0000, "R1 readback mask", 64'(cfg_rdata), 64'hFF00_0000);
        cfg_addr = 8'h40;
        #1 chk(cfg_rdata == 32'h0, "R1 beyond last window", 64'(cfg_rdata), 64'h0);

        for (int i = 0; i < NV; i++) run_cmd(VEC[i], "R4-table");

        // R2: enabling window 3 makes the earlier miss a hit
        reg_wr(8'h3C, 32'h0033_0001);
        run_cmd('{32'h8000_0000, 6'd1, 1'b0, 8'h33, 34'h0, 1'b0, 4'b1000}, "R2 enable");

        // R3: with window 0 off, window 1 takes the overlapping address
        reg_wr(8'h0C, 32'h0011_0000);
        run_cmd('{32'h1200_0010, 6'd5, 1'b0, 8'h22, 34'h0_D000_0040, 1'b0, 4'b1100}, "R3 next window");

        // R10: stall holds the header and raises wait
        out_ready = 1'b0;
        run_cmd('{32'hC000_0004, 6'd1, 1'b0, 8'hCC, 34'h1_0000_0010, 1'b1, 4'b1000}, "R10 first");
        avs_read = 1'b1; avs_address = 32'hC000_0000; avs_burstcount = 6'd9;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(avs_waitrequest == 1'b1, "R10 wait", 64'(avs_waitrequest), 64'h1);
            chk(out_rio_addr == 34'h1_0000_0010, "R10 hold addr", 64'(out_rio_addr), 64'h1_0000_0010);
            chk(out_rdsize == 4'b1000, "R10 hold size", 64'(out_rdsize), 64'h8);
        end
        out_ready = 1'b1;
        #1 chk(avs_waitrequest == 1'b0, "R10 release", 64'(avs_waitrequest), 64'h0);
        @(negedge clk);
        avs_read = 1'b0;
        chk(out_valid == 1'b1, "R11 second valid", 64'(out_valid), 64'h1);
        chk(out_rdsize == 4'b1100, "R6 second size", 64'(out_rdsize), 64'hC);
        chk(out_wdptr == 1'b1, "R6 second wdptr", 64'(out_wdptr), 64'h1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 drained", 64'(out_valid), 64'h0);

        finish_run();
    end
endmodule